// File: doc/BRIEF.md
# Interrupt and Trap Vector Controller

This block decides when a small 32-bit processor leaves its normal instruction stream for a handler, and where that handler is. It holds a vector-table base register, which software loads with a dedicated instruction. It watches four kinds of event: leaving reset, an undefined opcode, a software trap and a level-sensitive external interrupt. When an event is taken, the block produces a one-cycle redirect strobe. With that strobe it gives the handler address, which is the base plus a fixed slot offset for the event. It also gives the address the handler should later return to.

A masking flag provides atomic sections. A lock command inverts the flag, a return-from-handler command clears it, and taking an interrupt or a trap sets it. While the flag is set, the external request is not serviced and is not consumed. Because the request is a level, it stays pending and is taken as soon as the flag drops. Instruction decode and the general register file are outside this block. The decoder presents single-cycle strobes, together with the address of the instruction being executed.

Top module: `trap_vector_ctrl`

## Requirements
- R1: While reset is held, all outputs are 0. In the first cycle after reset is released, a reset redirect is issued with target base+0x0 (base is 0x0 after reset) and return address 0x0.
- R2: The handler target is base+offset. The offsets are 0x0 for reset, 0x4 for undefined instruction, 0x8 for external interrupt and 0xC for software trap, with the sum wrapping modulo 2^32.
- R3: A base write with `base_we_i` high loads `base_wdata_i` at the clock edge. An event taken at that same edge still uses the previous base.
- R4: When events coincide, exactly one is taken, in the priority order reset > undefined > trap > interrupt.
- R5: The return address is `pc_i`+4, wrapping modulo 2^32, for undefined, trap and interrupt events.
- R6: `irq_ack_o` is high exactly in the cycle of a redirect caused by the external interrupt, and low for every other redirect.
- R7: A lock strobe inverts the masking flag (`blocked_o`), unless a return strobe or a flag-setting event occurs in the same cycle.
- R8: While the flag is set, an asserted `irq_req_i` causes no redirect and no acknowledge. The request stays pending and is taken in the cycle after the flag clears, if it is still asserted.
- R9: A return strobe clears the flag and overrides a lock strobe in the same cycle.
- R10: Taking an interrupt or a trap sets the flag, overriding a return or a lock in the same cycle. An undefined-instruction event or a reset event leaves the flag unchanged.
- R11: All outputs are registered. A request sampled at a clock edge appears on the outputs after that edge, and the redirect strobe lasts one cycle for each event taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 1 | External interrupt request, level sensitive |
| trap_i | input | 1 | Software trap strobe from decode |
| undef_i | input | 1 | Undefined-instruction strobe from decode |
| lock_i | input | 1 | Toggle the masking flag |
| ret_i | input | 1 | Return from handler; clears the masking flag |
| base_we_i | input | 1 | Load the vector-table base register |
| base_wdata_i | input | 32 | New vector-table base value |
| pc_i | input | 32 | Address of the instruction now executing |
| redirect_o | output | 1 | One-cycle strobe: jump to `target_o` |
| target_o | output | 32 | Handler address |
| ret_addr_o | output | 32 | Return address for the handler to save |
| irq_ack_o | output | 1 | External interrupt accepted |
| blocked_o | output | 1 | Masking flag state |

## Verification
The hardest situation to reach is a held interrupt that becomes serviceable. The request must stay asserted for several cycles while the flag is set, and then the flag must drop through either a lock or a return. The acknowledge must appear exactly one cycle after that, not in the cycle of the clearing command. The stimulus first sets the flag with a lock and holds the request high. It then clears the flag once with a second lock and once with a return. The stimulus also raises a trap and a return together while the request is high, to check that the trap wins both the priority and the flag update.

// File: rtl/tvc_pkg.sv
package tvc_pkg;

  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_RESET = 3'd1,
    EV_UNDEF = 3'd2,
    EV_TRAP  = 3'd3,
    EV_IRQ   = 3'd4
  } tvc_event_e;

  localparam int N_SOURCES = 4;
  localparam int SRC_RESET = 0;
  localparam int SRC_UNDEF = 1;
  localparam int SRC_TRAP  = 2;
  localparam int SRC_IRQ   = 3;

  // Slot index inside the vector table; the slot times the slot size is the offset.
  function automatic logic [1:0] vec_slot(input tvc_event_e ev);
    case (ev)
      EV_UNDEF: vec_slot = 2'd1;
      EV_IRQ:   vec_slot = 2'd2;
      EV_TRAP:  vec_slot = 2'd3;
      default:  vec_slot = 2'd0;
    endcase
  endfunction

  // Events that raise the masking flag when taken.
  function automatic logic ev_sets_block(input tvc_event_e ev);
    ev_sets_block = (ev == EV_IRQ) || (ev == EV_TRAP);
  endfunction

endpackage

// File: rtl/tvc_event_arbiter.sv
module tvc_event_arbiter
  import tvc_pkg::*;
(
  input  logic                 reset_pend_i,
  input  logic                 undef_i,
  input  logic                 trap_i,
  input  logic                 irq_req_i,
  input  logic                 blocked_i,
  output tvc_event_e           event_o,
  output logic [N_SOURCES-1:0] grant_o,
  output logic                 irq_held_o
);

  logic [N_SOURCES-1:0] raw;
  logic [N_SOURCES-1:0] higher;

  assign raw[SRC_RESET] = reset_pend_i;
  assign raw[SRC_UNDEF] = undef_i;
  assign raw[SRC_TRAP]  = trap_i;
  assign raw[SRC_IRQ]   = irq_req_i & ~blocked_i;

  assign irq_held_o = irq_req_i & blocked_i;

  // Fixed priority: lower source index wins.
  assign higher[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < N_SOURCES; g++) begin : g_pri
      assign higher[g] = higher[g-1] | raw[g-1];
    end
  endgenerate

  assign grant_o = raw & ~higher;

  always_comb begin
    event_o = EV_NONE;
    if (grant_o[SRC_RESET])      event_o = EV_RESET;
    else if (grant_o[SRC_UNDEF]) event_o = EV_UNDEF;
    else if (grant_o[SRC_TRAP])  event_o = EV_TRAP;
    else if (grant_o[SRC_IRQ])   event_o = EV_IRQ;
  end

endmodule

// File: rtl/tvc_block_flag.sv
module tvc_block_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic toggle_i,
  output logic blocked_o
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i)         flag_d = 1'b1;
    else if (clr_i)    flag_d = 1'b0;
    else if (toggle_i) flag_d = ~flag_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign blocked_o = flag_q;

endmodule

// File: rtl/tvc_vector_base.sv
module tvc_vector_base
  import tvc_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          SLOT_BYTES  = 4,
  parameter int          INSTR_BYTES = 4,
  parameter logic [31:0] RESET_BASE  = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  tvc_event_e        event_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] ret_addr_o
);

  localparam logic [ADDR_W-1:0] SLOT_SZ  = ADDR_W'(SLOT_BYTES);
  localparam logic [ADDR_W-1:0] STEP_SZ  = ADDR_W'(INSTR_BYTES);
  localparam logic [ADDR_W-1:0] BASE_RST = ADDR_W'(RESET_BASE);

  function automatic logic [ADDR_W-1:0] handler_addr(
    input logic [ADDR_W-1:0] base,
    input tvc_event_e        ev
  );
    handler_addr = base + (ADDR_W'(vec_slot(ev)) * SLOT_SZ);
  endfunction

  function automatic logic [ADDR_W-1:0] resume_addr(
    input logic [ADDR_W-1:0] pc,
    input tvc_event_e        ev
  );
    resume_addr = (ev == EV_RESET) ? '0 : pc + STEP_SZ;
  endfunction

  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       base_q <= BASE_RST;
    else if (wr_en_i) base_q <= wr_data_i;
  end

  assign base_o     = base_q;
  assign target_o   = handler_addr(base_q, event_i);
  assign ret_addr_o = resume_addr(pc_i, event_i);

endmodule

// File: rtl/trap_vector_ctrl.sv
module trap_vector_ctrl
  import tvc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SLOT_BYTES  = 4,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req_i,
  input  logic              trap_i,
  input  logic              undef_i,
  input  logic              lock_i,
  input  logic              ret_i,
  input  logic              base_we_i,
  input  logic [ADDR_W-1:0] base_wdata_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic              irq_ack_o,
  output logic              blocked_o
);

  // Named internal events, visible to the bound checker.
  logic                 reset_pend_q;
  tvc_event_e           take_evt;
  logic [N_SOURCES-1:0] evt_grant;
  logic                 irq_held;
  logic                 take_any;
  logic                 take_sets_block;
  logic [ADDR_W-1:0]    base_val;
  logic [ADDR_W-1:0]    target_d;
  logic [ADDR_W-1:0]    ret_d;

  tvc_event_arbiter u_arb (
    .reset_pend_i (reset_pend_q),
    .undef_i      (undef_i),
    .trap_i       (trap_i),
    .irq_req_i    (irq_req_i),
    .blocked_i    (blocked_o),
    .event_o      (take_evt),
    .grant_o      (evt_grant),
    .irq_held_o   (irq_held)
  );

  assign take_any        = (take_evt != EV_NONE);
  assign take_sets_block = ev_sets_block(take_evt);

  tvc_block_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (take_sets_block),
    .clr_i     (ret_i),
    .toggle_i  (lock_i),
    .blocked_o (blocked_o)
  );

  tvc_vector_base #(
    .ADDR_W      (ADDR_W),
    .SLOT_BYTES  (SLOT_BYTES),
    .INSTR_BYTES (INSTR_BYTES),
    .RESET_BASE  (32'h0)
  ) u_base (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (base_we_i),
    .wr_data_i  (base_wdata_i),
    .event_i    (take_evt),
    .pc_i       (pc_i),
    .base_o     (base_val),
    .target_o   (target_d),
    .ret_addr_o (ret_d)
  );

  // A pending reset redirect is issued in the first cycle after reset.
  always_ff @(posedge clk) begin
    if (!rst_n) reset_pend_q <= 1'b1;
    else        reset_pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_o <= 1'b0;
      target_o   <= '0;
      ret_addr_o <= '0;
      irq_ack_o  <= 1'b0;
    end else begin
      redirect_o <= take_any;
      irq_ack_o  <= (take_evt == EV_IRQ);
      if (take_any) begin
        target_o   <= target_d;
        ret_addr_o <= ret_d;
      end
    end
  end

endmodule

// File: rtl/tvc_checker.sv
module tvc_checker
  import tvc_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 undef_i,
  input logic                 trap_i,
  input logic                 lock_i,
  input logic                 ret_i,
  input logic                 reset_pend_q,
  input logic                 irq_held,
  input logic [N_SOURCES-1:0] evt_grant,
  input logic                 take_sets_block,
  input logic                 redirect_o,
  input logic                 irq_ack_o,
  input logic                 blocked_o
);

  a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt_grant));

  a_r6_ack_needs_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> redirect_o);

  a_r10_ack_implies_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> blocked_o);

  a_r8_held_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_held && !undef_i && !trap_i && !reset_pend_q) |=> !redirect_o);

  a_r7_lock_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && !ret_i && !take_sets_block) |=> (blocked_o != $past(blocked_o)));

  a_r9_ret_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !take_sets_block) |=> !blocked_o);

endmodule

bind trap_vector_ctrl tvc_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .undef_i         (undef_i),
  .trap_i          (trap_i),
  .lock_i          (lock_i),
  .ret_i           (ret_i),
  .reset_pend_q    (reset_pend_q),
  .irq_held        (irq_held),
  .evt_grant       (evt_grant),
  .take_sets_block (take_sets_block),
  .redirect_o      (redirect_o),
  .irq_ack_o       (irq_ack_o),
  .blocked_o       (blocked_o)
);

// File: tb/trap_vector_ctrl_tb.sv
module trap_vector_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req_i = 1'b0, trap_i = 1'b0, undef_i = 1'b0;
  logic        lock_i = 1'b0, ret_i = 1'b0, base_we_i = 1'b0;
  logic [31:0] base_wdata_i = '0, pc_i = '0;
  logic        redirect_o, irq_ack_o, blocked_o;
  logic [31:0] target_o, ret_addr_o;

  always #2.5 clk = ~clk;

  trap_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .trap_i(trap_i),
    .undef_i(undef_i), .lock_i(lock_i), .ret_i(ret_i), .base_we_i(base_we_i),
    .base_wdata_i(base_wdata_i), .pc_i(pc_i), .redirect_o(redirect_o),
    .target_o(target_o), .ret_addr_o(ret_addr_o), .irq_ack_o(irq_ack_o),
    .blocked_o(blocked_o)
  );

  typedef struct {
    string       tag;
    logic        redir;
    logic [31:0] tgt;
    logic [31:0] ra;
    logic        ack;
    logic        blk;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  int   cycles   = 0;
  bit   done     = 0;

  // Monitor: compares one expected item per cycle, away from the rising edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      bit   bad;
      e = exp_q.pop_front();
      n_checks++;
      bad = (redirect_o !== e.redir) || (irq_ack_o !== e.ack) || (blocked_o !== e.blk);
      if (e.redir && ((target_o !== e.tgt) || (ret_addr_o !== e.ra))) bad = 1;
      if (bad) begin
        n_errors++;
        $display("FAIL %s: actual redir=%0b tgt=%h ra=%h ack=%0b blk=%0b expected redir=%0b tgt=%h ra=%h ack=%0b blk=%0b",
                 e.tag, redirect_o, target_o, ret_addr_o, irq_ack_o, blocked_o,
                 e.redir, e.tgt, e.ra, e.ack, e.blk);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_errors++;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  // Driver: applies one cycle of stimulus and queues the expected outcome.
  task automatic step(input logic irq, input logic trp, input logic und,
                      input logic lck, input logic rt, input logic we,
                      input logic [31:0] wd, input logic [31:0] pc,
                      input string tag, input logic e_redir, input logic [31:0] e_tgt,
                      input logic [31:0] e_ra, input logic e_ack, input logic e_blk);
    exp_t e;
    @(negedge clk); #1;
    irq_req_i = irq; trap_i = trp; undef_i = und; lock_i = lck; ret_i = rt;
    base_we_i = we; base_wdata_i = wd; pc_i = pc;
    e.tag = tag; e.redir = e_redir; e.tgt = e_tgt; e.ra = e_ra; e.ack = e_ack; e.blk = e_blk;
    exp_q.push_back(e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;
    if (redirect_o !== 1'b0 || irq_ack_o !== 1'b0 || blocked_o !== 1'b0 ||
        target_o !== 32'h0 || ret_addr_o !== 32'h0) begin
      n_errors++;
      $display("FAIL R1 reset state: actual redir=%0b tgt=%h ra=%h ack=%0b blk=%0b expected all 0",
               redirect_o, target_o, ret_addr_o, irq_ack_o, blocked_o);
    end
    @(negedge clk); #1; rst_n = 1'b1;
    exp_q.push_back('{tag:"R1 reset vector", redir:1, tgt:32'h0, ra:32'h0, ack:0, blk:0});
    //   irq trp und lck rt  we  wdata          pc
    step(0, 0, 0, 0, 0, 0, 32'h0, 32'h0, "R11 idle single pulse", 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 32'h0, 32'h100, "R2 R5 undef vector", 1, 32'h4, 32'h104, 0, 0);
    step(0, 0, 1, 0, 0, 1, 32'h8000, 32'h200, "R3 same-edge write uses old base", 1, 32'h4, 32'h204, 0, 0);
    step(0, 1, 0, 0, 0, 0, 32'h0, 32'h300, "R2 R10 trap vector sets block", 1, 32'h800C, 32'h304, 0, 1);
    step(0, 0, 0, 0, 1, 0, 32'h0, 32'h0, "R9 ret clears", 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 32'h0, 32'h400, "R2 R6 irq taken", 1, 32'h8008, 32'h404, 1, 1);
    step(1, 0, 0, 0, 0, 0, 32'h0, 32'h404, "R8 level irq not re-entered", 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1, 0, 32'h0, 32'h0, "R9 ret after handler", 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 32'h0, 32'h0, "R7 lock sets", 0, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++)
      step(1, 0, 0, 0, 0, 0, 32'h0, 32'h500, "R8 irq held while blocked", 0, 0, 0, 0, 1);
    step(1, 0, 0, 1, 0, 0, 32'h0, 32'h500, "R7 R8 lock clears, irq still held", 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 32'h0, 32'h508, "R8 pending irq taken after unblock", 1, 32'h8008, 32'h50C, 1, 1);
    step(0, 0, 0, 1, 1, 0, 32'h0, 32'h0, "R9 ret overrides lock", 0, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 32'h0, 32'h600, "R4 undef beats trap and irq", 1, 32'h8004, 32'h604, 0, 0);
    step(1, 1, 0, 0, 0, 0, 32'h0, 32'h700, "R4 trap beats irq", 1, 32'h800C, 32'h704, 0, 1);
    step(1, 0, 0, 0, 1, 0, 32'h0, 32'h704, "R8 R9 ret clears, irq waits", 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 32'h0, 32'h710, "R6 R8 irq taken after ret", 1, 32'h8008, 32'h714, 1, 1);
    step(1, 1, 0, 1, 1, 0, 32'h0, 32'h800, "R10 trap overrides ret and lock", 1, 32'h800C, 32'h804, 0, 1);
    step(0, 0, 0, 0, 1, 1, 32'hFFFF_FFF8, 32'h0, "R3 base write", 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 32'h0, 32'hFFFF_FFFC, "R2 R5 wrap of target and return", 1, 32'h4, 32'h0, 0, 1);
    step(0, 0, 1, 0, 0, 0, 32'h0, 32'h900, "R10 undef keeps block set", 1, 32'hFFFF_FFFC, 32'h904, 0, 1);
    step(0, 0, 0, 1, 0, 0, 32'h0, 32'h0, "R7 lock toggles off", 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 32'h0, 32'h0, "R7 lock toggles on", 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 32'h0, 32'h0, "R11 no stray redirect", 0, 0, 0, 0, 1);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule